// File: doc/BRIEF.md
# Serial Clock-Domain Register Access Master

This block lets a host read or write the registers of a slow real-time-clock domain over a three-wire serial link. The link has an enable line, a serial clock and a host-to-domain data line. A return data line and a ready flag come back from the domain. The host side is a one-shot request port: a direction bit, a 3-bit register address and a 32-bit write word. The block answers with a one-cycle completion strobe, an error flag and, for reads, a 32-bit result.

A transaction first drops all three link outputs. It then polls the domain's ready flag in fixed-length windows with a settle gap between them. Windows are grouped into initialisation attempts. When a whole group of attempts fails, the block pulses a reset line into the domain and starts over. When every reset has been used, the request completes with an error.

Once ready is seen, the frame is shifted most-significant bit first, one bit per clock pulse:
- A write sends the 32 data bits, then the 3 address bits.
- A read sends the 3 address bits and then collects 32 reply bits.

Between the two parts, a single mode bit is sent with enable low: 1 selects write, 0 selects read.

Top module: `rtc_serial_master`

## Requirements
- R1: After reset, busy, done, error, enable, serial clock, serial data in and the domain reset are all 0, and the read result is 0.
- R2: Once a request is accepted, enable, serial clock and data in stay 0 until the ready flag is seen. Enable rises only in the cycle after a cycle in which ready was 1.
- R3: Each serial clock pulse holds the clock low for HALF_CYC cycles and then high for HALF_CYC cycles. Data in never changes while the clock is high.
- R4: A write frame has exactly 36 clock pulses. Pulses 0-31 carry the write data, bit 31 first, and pulses 32-34 carry the address, bit 2 first, all with enable 1. Pulse 35 has enable 0 and data in 1.
- R5: A read frame has exactly 36 clock pulses. Pulses 0-2 carry the address, bit 2 first, with enable 1. Pulse 3 has enable 0 and data in 0. On pulses 4-35, one bit of serial data out is sampled at the end of each pulse and shifted in from the LSB side, so the first bit received becomes bit 31.
- R6: The ready flag is polled in windows of POLL_LIMIT cycles, separated by SETTLE_CYC-cycle gaps.
  - WAIT_TRIES failed windows make one failed initialisation.
  - INIT_TRIES failed initialisations raise the domain reset for one cycle and restart the count.
  - After RESET_TRIES resets, one more failed group ends the request with error.
  - With the defaults, this is 142 busy cycles and 2 reset pulses.
- R7: busy is 1 from the cycle after acceptance until completion. Requests presented while busy are ignored and start no frame.
- R8: done is 1 for exactly one cycle per request, and busy is 0 in that cycle. error is only ever 1 together with done. A request that finds ready completes with error 0.
- R9: The read result changes only when a read completes without error. It holds its value through later writes and failed requests.
- R10: Ready arriving in a later poll window, including one after a domain reset, still gives a normal frame with error 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Domain register address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transaction in progress |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_error | output | 1 | Ready never seen, valid with done |
| rsp_rdata | output | DATA_W | Last read result |
| ser_en | output | 1 | Serial enable to the domain |
| ser_clk | output | 1 | Serial clock to the domain |
| ser_din | output | 1 | Serial data to the domain |
| ser_dout | input | 1 | Serial data from the domain |
| ser_ready | input | 1 | Domain ready flag |
| dom_reset | output | 1 | One-cycle reset pulse to the domain |

## Verification
The assertions check the link's cycle-level rules on every cycle:
- enable only rises after ready;
- the clock's high width is exact;
- data in holds still while the clock is high;
- the link is quiet whenever the block is idle;
- done is a single cycle, and error only appears with it;
- the read result holds while idle.

Only the bench's scenarios can show the frame contents and their bit order, the reassembly of read data, the exact length of the retry sequence and its reset count, and the refusal of requests while busy. These depend on a model of the domain and on whole-transaction counts.

// File: rtl/rtc_serial_master.sv
module rtc_serial_master #(
  parameter int HALF_CYC    = 2,
  parameter int POLL_LIMIT  = 8,
  parameter int SETTLE_CYC  = 4,
  parameter int WAIT_TRIES  = 2,
  parameter int INIT_TRIES  = 2,
  parameter int RESET_TRIES = 2,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_done,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ser_en,
  output logic              ser_clk,
  output logic              ser_din,
  input  logic              ser_dout,
  input  logic              ser_ready,
  output logic              dom_reset
);

  localparam int FW   = ADDR_W + DATA_W;
  localparam int NW   = $clog2(FW + 1);
  localparam int T1   = (HALF_CYC > POLL_LIMIT) ? HALF_CYC : POLL_LIMIT;
  localparam int TMAX = (T1 > SETTLE_CYC) ? T1 : SETTLE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int CW   = $clog2(WAIT_TRIES + INIT_TRIES + RESET_TRIES + 1) + 1;

  localparam logic [TW-1:0] HALF_END   = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] POLL_END   = TW'(POLL_LIMIT - 1);
  localparam logic [TW-1:0] SETTLE_END = TW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] WAIT_LAST  = CW'(WAIT_TRIES - 1);
  localparam logic [CW-1:0] INIT_LAST  = CW'(INIT_TRIES - 1);
  localparam logic [CW-1:0] RST_MAX    = CW'(RESET_TRIES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL, ST_SETTLE, ST_DRST, ST_SHIFT, ST_MODE_EN, ST_MODE, ST_RECV
  } st_t;

  st_t               st;
  logic [TW-1:0]     tmr;
  logic              ph;
  logic              wr;
  logic [FW-1:0]     sh;
  logic [NW-1:0]     nb;
  logic [DATA_W-1:0] rx;
  logic [CW-1:0]     att, fails, resets;

  wire pulsing   = (st == ST_SHIFT) || (st == ST_MODE) || (st == ST_RECV);
  wire pulse_end = pulsing && ph && (tmr == HALF_END);
  wire last_bit  = (nb == NW'(1));

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tmr       <= '0;
      ph        <= 1'b0;
      wr        <= 1'b0;
      sh        <= '0;
      nb        <= '0;
      rx        <= '0;
      att       <= '0;
      fails     <= '0;
      resets    <= '0;
      rsp_done  <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
      ser_en    <= 1'b0;
      ser_clk   <= 1'b0;
      ser_din   <= 1'b0;
      dom_reset <= 1'b0;
    end else begin
      rsp_done  <= 1'b0;
      rsp_error <= 1'b0;
      dom_reset <= 1'b0;

      if (pulsing) begin
        if (tmr == HALF_END) begin
          tmr     <= '0;
          ph      <= ~ph;
          ser_clk <= ~ph;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end

      case (st)
        ST_IDLE: if (req_valid) begin
          wr      <= req_write;
          sh      <= req_write ? {req_wdata, req_addr} : {req_addr, {DATA_W{1'b0}}};
          nb      <= req_write ? NW'(FW) : NW'(ADDR_W);
          ser_en  <= 1'b0;
          ser_clk <= 1'b0;
          ser_din <= 1'b0;
          tmr     <= '0;
          ph      <= 1'b0;
          att     <= '0;
          fails   <= '0;
          resets  <= '0;
          st      <= ST_POLL;
        end

        ST_POLL: begin
          if (ser_ready) begin
            ser_en  <= 1'b1;
            ser_din <= sh[FW-1];
            tmr     <= '0;
            ph      <= 1'b0;
            st      <= ST_SHIFT;
          end else if (tmr == POLL_END) begin
            tmr <= '0;
            if (att != WAIT_LAST) begin
              att <= att + 1'b1;
              st  <= ST_SETTLE;
            end else begin
              att <= '0;
              if (fails != INIT_LAST) begin
                fails <= fails + 1'b1;
                st    <= ST_SETTLE;
              end else begin
                fails <= '0;
                if (resets != RST_MAX) begin
                  resets    <= resets + 1'b1;
                  dom_reset <= 1'b1;
                  st        <= ST_DRST;
                end else begin
                  rsp_done  <= 1'b1;
                  rsp_error <= 1'b1;
                  st        <= ST_IDLE;
                end
              end
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end

        ST_DRST: st <= ST_SETTLE;

        ST_SETTLE: begin
          if (tmr == SETTLE_END) begin
            tmr <= '0;
            st  <= ST_POLL;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end

        ST_SHIFT: if (pulse_end) begin
          if (last_bit) begin
            ser_en  <= 1'b0;
            ser_din <= 1'b0;
            st      <= ST_MODE_EN;
          end else begin
            sh      <= sh << 1;
            ser_din <= sh[FW-2];
            nb      <= nb - 1'b1;
          end
        end

        ST_MODE_EN: begin
          ser_din <= wr;
          tmr     <= '0;
          ph      <= 1'b0;
          st      <= ST_MODE;
        end

        ST_MODE: if (pulse_end) begin
          ser_din <= 1'b0;
          if (wr) begin
            rsp_done <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            nb <= NW'(DATA_W);
            st <= ST_RECV;
          end
        end

        ST_RECV: if (pulse_end) begin
          rx <= {rx[DATA_W-2:0], ser_dout};
          nb <= nb - 1'b1;
          if (last_bit) begin
            rsp_rdata <= {rx[DATA_W-2:0], ser_dout};
            rsp_done  <= 1'b1;
            st        <= ST_IDLE;
          end
        end

        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rtc_serial_master_chk.sv
module rtc_serial_master_chk #(
  parameter int HALF_CYC = 2,
  parameter int DATA_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              rsp_done,
  input logic              rsp_error,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              ser_en,
  input logic              ser_clk,
  input logic              ser_din,
  input logic              ser_ready,
  input logic              dom_reset
);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (ser_clk) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  a_r2_en_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_en) |-> $past(ser_ready));

  a_r3_din_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_din));

  a_r3_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> (hi_cnt == 16'(HALF_CYC)));

  a_r6_reset_off_link: assert property (@(posedge clk) disable iff (!rst_n)
    dom_reset |-> (busy && !ser_en));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_en && !ser_clk));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r8_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> (rsp_done && !busy));

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> $stable(rsp_rdata));

endmodule

bind rtc_serial_master rtc_serial_master_chk #(.HALF_CYC(HALF_CYC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
  .ser_en(ser_en), .ser_clk(ser_clk), .ser_din(ser_din),
  .ser_ready(ser_ready), .dom_reset(dom_reset)
);

// File: tb/test_rtc_serial_master.sv
`timescale 1ns/1ps
module test_rtc_serial_master;
  localparam int HALF = 2, POLL = 8, SETTLE = 4, WT = 2, IT = 2, RT = 2;
  localparam int FAIL_CYC = WT*IT*(RT+1)*POLL + (WT*IT*(RT+1)-1)*SETTLE + RT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic busy, rsp_done, rsp_error, ser_en, ser_clk, ser_din, dom_reset;
  logic [31:0] rsp_rdata;
  logic ser_dout = 1'b0, ser_ready = 1'b1;

  always #5 clk = ~clk;

  rtc_serial_master #(.HALF_CYC(HALF), .POLL_LIMIT(POLL), .SETTLE_CYC(SETTLE),
    .WAIT_TRIES(WT), .INIT_TRIES(IT), .RESET_TRIES(RT)) i_rtc_serial_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rsp_done(rsp_done),
    .rsp_error(rsp_error), .rsp_rdata(rsp_rdata), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_ready(ser_ready), .dom_reset(dom_reset));

  int checks = 0, fails = 0;

  // domain model: logs every pulse, answers reads after the mode bit
  logic log_en [128];
  logic log_din[128];
  int npulse = 0, k = 0;
  bit mode_seen = 0;
  logic [31:0] rpat = '0;
  always @(posedge ser_clk) begin
    log_en[npulse % 128]  = ser_en;
    log_din[npulse % 128] = ser_din;
    npulse++;
    if (ser_en) begin
      mode_seen = 0;
      k = 0;
    end else if (!mode_seen) begin
      mode_seen = 1;
    end else if (k < 32) begin
      ser_dout = rpat[31-k];
      k++;
    end
  end

  // cycle monitors
  int hw = 0, wbad = 0, dbad = 0, nrst = 0, busy_cyc = 0;
  logic prev_clk = 1'b0, prev_din = 1'b0;
  always @(negedge clk) begin
    if (ser_clk) hw++;
    else begin
      if (hw != 0 && hw != HALF) wbad++;
      hw = 0;
    end
    if (ser_clk && prev_clk && ser_din != prev_din) dbad++;
    prev_clk = ser_clk;
    prev_din = ser_din;
    if (dom_reset) nrst++;
    if (busy) busy_cyc++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output int t);
    t = 0;
    while (!rsp_done && t < 3000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic run_txn(input bit wr, input logic [2:0] a, input logic [31:0] d,
                         input int dly, input int exp_rst);
    int base, r0, w0, d0, t, bad;
    logic [31:0] old_rd;
    base = npulse; r0 = nrst; w0 = wbad; d0 = dbad; old_rd = rsp_rdata;
    rpat = d;
    if (dly > 0) ser_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wr ? d : 32'hFFFF_FFFF;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7", "busy after accept", 32'(busy), 32'd1);
    repeat (3) @(negedge clk);
    chk(dly < 4 || (!ser_en && !ser_clk && !ser_din), "R2", "link low before ready",
        {29'd0, ser_en, ser_clk, ser_din}, 32'd0);
    // stray request while busy must be ignored (R7)
    req_valid = 1'b1; req_write = ~wr; req_addr = ~a;
    @(negedge clk);
    req_valid = 1'b0;
    if (dly > 5) repeat (dly - 5) @(negedge clk);
    ser_ready = 1'b1;
    wait_done(t);
    chk(rsp_done == 1'b1, "R8", "done seen", 32'(rsp_done), 32'd1);
    chk(rsp_error == 1'b0 && busy == 1'b0, "R8", "no error, idle at done",
        {30'd0, rsp_error, busy}, 32'd0);
    chk(npulse - base == 36, wr ? "R4" : "R5", "pulse count", 32'(npulse - base), 32'd36);
    bad = 0;
    for (int i = 0; i < 36; i++) begin
      logic e, b;
      if (wr) begin
        e = (i < 35);
        b = (i < 32) ? d[31-i] : (i < 35) ? a[2-(i-32)] : 1'b1;
      end else begin
        e = (i < 3);
        b = (i < 3) ? a[2-i] : 1'b0;
      end
      if (log_en[(base+i) % 128] !== e) bad++;
      if ((wr || i < 4) && log_din[(base+i) % 128] !== b) bad++;
    end
    chk(bad == 0, wr ? "R4" : "R5", "frame bits", 32'(bad), 32'd0);
    if (wr) chk(rsp_rdata == old_rd, "R9", "rdata kept over write", rsp_rdata, old_rd);
    else    chk(rsp_rdata == d, "R5", "read data", rsp_rdata, d);
    chk(wbad == w0 && dbad == d0, "R3", "pulse width and din hold",
        32'(wbad - w0 + dbad - d0), 32'd0);
    chk(nrst - r0 == exp_rst, "R10", "domain resets", 32'(nrst - r0), 32'(exp_rst));
    @(negedge clk);
    chk(rsp_done == 1'b0, "R8", "done one cycle", 32'(rsp_done), 32'd0);
    base = npulse;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0 && npulse == base, "R7", "stray request ignored",
        32'(npulse - base), 32'd0);
  endtask

  // {write, addr[2:0], data[31:0], ready delay[7:0]}
  localparam logic [43:0] VEC [5] = '{
    {1'b1, 3'd5, 32'hA5C3_0F81, 8'd0},
    {1'b0, 3'd3, 32'h8000_0001, 8'd0},
    {1'b1, 3'd7, 32'h7FFF_FFFE, 8'd10},
    {1'b0, 3'd6, 32'hDEAD_BEEF, 8'd6},
    {1'b0, 3'd1, 32'h1234_5678, 8'd0}
  };

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int t, r0, p0, b0;
    logic [31:0] old_rd;
    repeat (3) @(negedge clk);
    chk({busy, rsp_done, rsp_error, ser_en, ser_clk, ser_din, dom_reset} == 7'd0,
        "R1", "outputs after reset",
        {25'd0, busy, rsp_done, rsp_error, ser_en, ser_clk, ser_din, dom_reset}, 32'd0);
    chk(rsp_rdata == 32'd0, "R1", "rdata after reset", rsp_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 5; v++)
      run_txn(VEC[v][43], VEC[v][42:40], VEC[v][39:8], int'(VEC[v][7:0]), 0);

    // R10: ready after the first domain reset
    run_txn(1'b0, 3'd2, 32'h0F0F_A5A5, 52, 1);

    // R6: ready never arrives
    old_rd = rsp_rdata;
    ser_ready = 1'b0;
    r0 = nrst; p0 = npulse; b0 = busy_cyc;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd4;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(t);
    chk(rsp_done && rsp_error, "R6", "error at end of retries",
        {30'd0, rsp_done, rsp_error}, 32'd3);
    chk(nrst - r0 == RT, "R6", "reset pulses", 32'(nrst - r0), 32'(RT));
    chk(busy_cyc - b0 == FAIL_CYC, "R6", "busy cycles", 32'(busy_cyc - b0), 32'(FAIL_CYC));
    chk(npulse == p0, "R2", "no pulses without ready", 32'(npulse - p0), 32'd0);
    chk(rsp_rdata == old_rd, "R9", "rdata kept over failure", rsp_rdata, old_rd);
    @(negedge clk);
    chk(rsp_done == 1'b0 && rsp_error == 1'b0, "R8", "error strobe one cycle",
        {30'd0, rsp_done, rsp_error}, 32'd0);
    ser_ready = 1'b1;

    // back-to-back after failure recovers
    run_txn(1'b0, 3'd0, 32'hFFFF_FFFF, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule